// File: doc/BRIEF.md
# Registered Command Buffer with Parity Check

This block sits between a memory controller and the devices on a memory module. On every rising clock edge it registers the address and command lanes and drives each registered value out on two matching copies, A and B. The fourteen data lanes are loaded only on edges where a command is present, which means at least one of the two active-low chip-select inputs is low. On all other edges the data lanes hold their value. The two chip-selects, the clock-enable lane and the termination-control lane are loaded on every edge.

An odd-parity check runs over every command that is loaded. The parity bit for a command arrives one cycle after the command, and the check is made on that later edge. A failed check drives an active-low error output after a fixed delay. The error output then stays low for a fixed number of cycles, and a new failure during that time extends it. A partial-parity output reports the parity of the fourteen captured data bits. A configuration input selects one of two register roles, and the block reflects that choice on a status output. An asynchronous active-low reset clears all state.

The data path carries no flow control. The block accepts a new command on every edge and never stalls, so it has no valid/ready handshake. It simply re-drives every input lane one cycle later.

Top module: `cmd_regbuf`

## Requirements
- R1: Every registered lane drives copy A and copy B, and the two copies always carry the same value.
- R2: At a rising edge where `cs0_n` or `cs1_n` is low, the 14 data lanes load `cmd_d`. At an edge where both are high, the data outputs keep their previous value.
- R3: Both chip-select inputs are registered on every rising edge and appear on their A and B outputs one edge later.
- R4: `cke_d` and `odt_d` are registered on every rising edge, whatever the chip-select state.
- R5: `par_in` is sampled only at the edge right after an edge that loaded a command. The check fails when the 14 captured data bits together with `par_in` hold an even number of ones. No check is made at any other edge.
- R6: At each check edge, `ppo` loads the XOR of the 14 captured data bits, which is 1 for an odd count of ones. Between check edges `ppo` holds its value.
- R7: For a failed check at edge m, `err_n` goes low right after edge m+2.
- R8: Without a further failure, `err_n` stays low for exactly two cycles (after edges m+2 and m+3) and is high again after edge m+4.
- R9: A further failure during the low period restarts the two-cycle window from the newer failure, so the low period is extended.
- R10: When `rst_n` goes low, all lane outputs, `ppo` and `role_q` go low at once and `err_n` goes high. Any pending check and any error pulse are discarded.
- R11: `role_q` registers `role_sel` on every edge: 0 selects the first register role and 1 selects the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| role_sel | input | 1 | Role select (0 first role, 1 second role) |
| cs0_n | input | 1 | Chip select 0, active low |
| cs1_n | input | 1 | Chip select 1, active low |
| cke_d | input | 1 | Clock-enable lane input |
| odt_d | input | 1 | Termination-control lane input |
| cmd_d | input | 14 | Gated address/command data lanes |
| par_in | input | 1 | Parity bit, one cycle after the command |
| cmd_qa | output | 14 | Data lanes, copy A |
| cmd_qb | output | 14 | Data lanes, copy B |
| cs0_qa | output | 1 | Registered chip select 0, copy A |
| cs0_qb | output | 1 | Registered chip select 0, copy B |
| cs1_qa | output | 1 | Registered chip select 1, copy A |
| cs1_qb | output | 1 | Registered chip select 1, copy B |
| cke_qa | output | 1 | Registered clock enable, copy A |
| cke_qb | output | 1 | Registered clock enable, copy B |
| odt_qa | output | 1 | Registered termination control, copy A |
| odt_qb | output | 1 | Registered termination control, copy B |
| ppo | output | 1 | Partial parity of the captured data bits |
| err_n | output | 1 | Parity error flag, active low |
| role_q | output | 1 | Registered role status |

## Verification
A corrupted data register shows up one edge later as a mismatch on `cmd_qa` or `cmd_qb`, or as a data lane that moves while both chip-selects are high. A lost or spurious pending-check flag changes `ppo` at the next edge. The same fault also changes `err_n` exactly two edges after that. A fault in the error delay stage or in the pulse counter makes the error pulse start early or late, or last the wrong number of cycles, and the error is visible within four edges of the failing check. The reference model compares every output after every edge, so the first wrong cycle is the one that gets reported.

// File: rtl/cmd_regbuf_pkg.sv
package cmd_regbuf_pkg;
  // number of always-registered control lanes: cs0, cs1, cke, odt
  localparam int unsigned CTRL_LANES = 4;
  localparam int unsigned CTRL_CS0   = 0;
  localparam int unsigned CTRL_CS1   = 1;
  localparam int unsigned CTRL_CKE   = 2;
  localparam int unsigned CTRL_ODT   = 3;

  typedef enum logic {
    ROLE_FIRST  = 1'b0,
    ROLE_SECOND = 1'b1
  } role_e;
endpackage

// File: rtl/cmd_regbuf_lanes.sv
// A bank of lanes loaded under an enable, duplicated into COPIES flop banks.
module cmd_regbuf_lanes #(
  parameter int unsigned W      = 14,
  parameter int unsigned COPIES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load,
  input  logic [W-1:0]                d,
  output logic [COPIES-1:0][W-1:0]    q
);
  for (genvar c = 0; c < COPIES; c++) begin : g_copy
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q[c] <= '0;
      else if (load) q[c] <= d;
    end
  end
endmodule

// File: rtl/cmd_regbuf_parity.sv
// Tracks a pending check for one cycle after a capture, then compares the
// late parity bit against the captured data.
module cmd_regbuf_parity #(
  parameter int unsigned W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic [W-1:0] held,
  input  logic         par_bit,
  output logic         ppo,
  output logic         mismatch
);
  logic pending;
  logic held_xor;

  assign held_xor = ^held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending  <= 1'b0;
      ppo      <= 1'b0;
      mismatch <= 1'b0;
    end else begin
      pending  <= capture;
      mismatch <= pending & ~(held_xor ^ par_bit);
      if (pending) ppo <= held_xor;
    end
  end
endmodule

// File: rtl/cmd_regbuf_errgen.sv
// Delays a failure indication by PIPE stages, then holds err_n low for PULSE
// cycles; a new failure reloads the counter.
module cmd_regbuf_errgen #(
  parameter int unsigned PIPE  = 1,
  parameter int unsigned PULSE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  output logic err_n
);
  localparam int unsigned CW = $clog2(PULSE + 1);

  logic          fire;
  logic [CW-1:0] cnt;

  if (PIPE == 0) begin : g_nopipe
    assign fire = hit;
  end else begin : g_pipe
    logic [PIPE-1:0] sr;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= '0;
      else        sr <= {sr[PIPE-1:0] , hit} >> 0;
    end
    assign fire = sr[PIPE-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (fire)     cnt <= CW'(PULSE);
    else if (cnt != 0) cnt <= cnt - 1'b1;
  end

  assign err_n = (cnt == '0);
endmodule

// File: rtl/cmd_regbuf.sv
module cmd_regbuf
  import cmd_regbuf_pkg::*;
#(
  parameter int unsigned LANES     = 14,
  parameter int unsigned ERR_PIPE  = 1,
  parameter int unsigned ERR_PULSE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             role_sel,
  input  logic             cs0_n,
  input  logic             cs1_n,
  input  logic             cke_d,
  input  logic             odt_d,
  input  logic [LANES-1:0] cmd_d,
  input  logic             par_in,
  output logic [LANES-1:0] cmd_qa,
  output logic [LANES-1:0] cmd_qb,
  output logic             cs0_qa,
  output logic             cs0_qb,
  output logic             cs1_qa,
  output logic             cs1_qb,
  output logic             cke_qa,
  output logic             cke_qb,
  output logic             odt_qa,
  output logic             odt_qb,
  output logic             ppo,
  output logic             err_n,
  output logic             role_q
);
  logic                              cmd_valid;
  logic [1:0][LANES-1:0]             data_q;
  logic [CTRL_LANES-1:0]             ctrl_d;
  logic [1:0][CTRL_LANES-1:0]        ctrl_q;
  logic                              hit;
  role_e                             role_r;

  assign cmd_valid = ~cs0_n | ~cs1_n;

  cmd_regbuf_lanes #(.W(LANES), .COPIES(2)) u_data (
    .clk  (clk),
    .rst_n(rst_n),
    .load (cmd_valid),
    .d    (cmd_d),
    .q    (data_q)
  );

  always_comb begin
    ctrl_d           = '0;
    ctrl_d[CTRL_CS0] = cs0_n;
    ctrl_d[CTRL_CS1] = cs1_n;
    ctrl_d[CTRL_CKE] = cke_d;
    ctrl_d[CTRL_ODT] = odt_d;
  end

  cmd_regbuf_lanes #(.W(CTRL_LANES), .COPIES(2)) u_ctrl (
    .clk  (clk),
    .rst_n(rst_n),
    .load (1'b1),
    .d    (ctrl_d),
    .q    (ctrl_q)
  );

  cmd_regbuf_parity #(.W(LANES)) u_par (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (cmd_valid),
    .held    (data_q[0]),
    .par_bit (par_in),
    .ppo     (ppo),
    .mismatch(hit)
  );

  cmd_regbuf_errgen #(.PIPE(ERR_PIPE), .PULSE(ERR_PULSE)) u_err (
    .clk  (clk),
    .rst_n(rst_n),
    .hit  (hit),
    .err_n(err_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) role_r <= ROLE_FIRST;
    else        role_r <= role_e'(role_sel);
  end

  assign role_q = role_r;
  assign cmd_qa = data_q[0];
  assign cmd_qb = data_q[1];
  assign cs0_qa = ctrl_q[0][CTRL_CS0];
  assign cs0_qb = ctrl_q[1][CTRL_CS0];
  assign cs1_qa = ctrl_q[0][CTRL_CS1];
  assign cs1_qb = ctrl_q[1][CTRL_CS1];
  assign cke_qa = ctrl_q[0][CTRL_CKE];
  assign cke_qb = ctrl_q[1][CTRL_CKE];
  assign odt_qa = ctrl_q[0][CTRL_ODT];
  assign odt_qb = ctrl_q[1][CTRL_ODT];
endmodule

// File: rtl/cmd_regbuf_chk.sv
module cmd_regbuf_chk #(
  parameter int unsigned LANES = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             role_sel,
  input logic             cs0_n,
  input logic             cs1_n,
  input logic             cke_d,
  input logic             odt_d,
  input logic [LANES-1:0] cmd_d,
  input logic [LANES-1:0] cmd_qa,
  input logic [LANES-1:0] cmd_qb,
  input logic             cs0_qa,
  input logic             cs0_qb,
  input logic             cs1_qa,
  input logic             cs1_qb,
  input logic             cke_qa,
  input logic             cke_qb,
  input logic             odt_qa,
  input logic             odt_qb,
  input logic             ppo,
  input logic             err_n,
  input logic             role_q
);
  // R1
  copies_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_qa == cmd_qb) && (cs0_qa == cs0_qb) && (cs1_qa == cs1_qb) &&
    (cke_qa == cke_qb) && (odt_qa == odt_qb));

  // R2
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs0_n && cs1_n) |=> $stable(cmd_qa));

  // R2
  data_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs0_n || !cs1_n) |=> (cmd_qa == $past(cmd_d)));

  // R3
  cs_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (cs0_qa == $past(cs0_n)) && (cs1_qa == $past(cs1_n)));

  // R4
  ctrl_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (cke_qa == $past(cke_d)) && (odt_qa == $past(odt_d)));

  // R8
  err_min_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_n) |=> !err_n);

  // R11
  role_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (role_q == $past(role_sel)));

  // R10
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_state_chk: assert (err_n && (cmd_qa == '0) && !cke_qa && !odt_qa &&
                               !cs0_qa && !cs1_qa && !ppo && !role_q);
    end
  end
endmodule

bind cmd_regbuf cmd_regbuf_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/cmd_regbuf_bench.sv
module cmd_regbuf_bench;
  localparam int LANES = 14;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             role_sel = 1'b0;
  logic             cs0_n = 1'b1;
  logic             cs1_n = 1'b1;
  logic             cke_d = 1'b0;
  logic             odt_d = 1'b0;
  logic [LANES-1:0] cmd_d = '0;
  logic             par_in = 1'b0;
  logic [LANES-1:0] cmd_qa, cmd_qb;
  logic cs0_qa, cs0_qb, cs1_qa, cs1_qb, cke_qa, cke_qb, odt_qa, odt_qb;
  logic ppo, err_n, role_q;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  cmd_regbuf u_cmd_regbuf (
    .clk(clk), .rst_n(rst_n), .role_sel(role_sel), .cs0_n(cs0_n), .cs1_n(cs1_n),
    .cke_d(cke_d), .odt_d(odt_d), .cmd_d(cmd_d), .par_in(par_in),
    .cmd_qa(cmd_qa), .cmd_qb(cmd_qb), .cs0_qa(cs0_qa), .cs0_qb(cs0_qb),
    .cs1_qa(cs1_qa), .cs1_qb(cs1_qb), .cke_qa(cke_qa), .cke_qb(cke_qb),
    .odt_qa(odt_qa), .odt_qb(odt_qb), .ppo(ppo), .err_n(err_n), .role_q(role_q)
  );

  always #10 clk = ~clk;

  // ---------------- behavioural reference model ----------------
  logic [LANES-1:0] m_data;
  bit m_cs0, m_cs1, m_cke, m_odt, m_ppo, m_role, m_pend;
  int edge_n = 0;
  int fail_edges[$];

  function automatic bit m_err_n();
    foreach (fail_edges[i]) begin
      if ((edge_n - fail_edges[i]) >= 2 && (edge_n - fail_edges[i]) <= 3) return 1'b0;
    end
    return 1'b1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_data = '0; m_cs0 = 0; m_cs1 = 0; m_cke = 0; m_odt = 0;
      m_ppo = 0; m_role = 0; m_pend = 0;
      fail_edges.delete();
    end else begin
      edge_n++;
      if (m_pend) begin
        m_ppo = ^m_data;
        if (((^m_data) ^ par_in) == 1'b0) fail_edges.push_back(edge_n);
      end
      while (fail_edges.size() > 0 && (edge_n - fail_edges[0]) > 3) void'(fail_edges.pop_front());
      m_pend = !cs0_n || !cs1_n;
      if (m_pend) m_data = cmd_d;
      m_cs0 = cs0_n; m_cs1 = cs1_n; m_cke = cke_d; m_odt = odt_d;
      m_role = role_sel;
    end
  end

  task automatic check_v(string req, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at edge %0d: actual %h expected %h", req, what, edge_n, act, exp);
    end
  endtask

  task automatic compare_all();
    check_v("R2", "cmd_qa", 32'(cmd_qa), 32'(m_data));
    check_v("R1", "cmd_qb", 32'(cmd_qb), 32'(m_data));
    check_v("R3", "cs0_qa", 32'(cs0_qa), 32'(m_cs0));
    check_v("R1", "cs0_qb", 32'(cs0_qb), 32'(m_cs0));
    check_v("R3", "cs1_qa", 32'(cs1_qa), 32'(m_cs1));
    check_v("R1", "cs1_qb", 32'(cs1_qb), 32'(m_cs1));
    check_v("R4", "cke_qa", 32'(cke_qa), 32'(m_cke));
    check_v("R1", "cke_qb", 32'(cke_qb), 32'(m_cke));
    check_v("R4", "odt_qa", 32'(odt_qa), 32'(m_odt));
    check_v("R1", "odt_qb", 32'(odt_qb), 32'(m_odt));
    check_v("R6", "ppo", 32'(ppo), 32'(m_ppo));
    check_v("R7_R8_R9", "err_n", 32'(err_n), 32'(m_err_n()));
    check_v("R11", "role_q", 32'(role_q), 32'(m_role));
  endtask

  function automatic logic good_par(logic [LANES-1:0] d);
    return ~(^d);
  endfunction

  // drive one cycle's inputs, then compare after the next edge
  task automatic cyc(bit c0, bit c1, logic [LANES-1:0] d, bit p, bit ke, bit ot, bit rl);
    cs0_n = c0; cs1_n = c1; cmd_d = d; par_in = p; cke_d = ke; odt_d = ot; role_sel = rl;
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(1, 1, 14'h2AAA, 1'b0, 1'b1, 1'b0, m_role);
  endtask

  initial begin
    @(negedge clk);
    // R10: reset state
    compare_all();
    @(negedge clk);
    rst_n = 1'b1;
    compare_all();

    // R2: no chip select, data ignored
    cyc(1, 1, 14'h1234, 0, 1, 1, 0);
    cyc(1, 1, 14'h3FFF, 1, 0, 1, 1);
    // R2/R5: capture on cs0, good parity next cycle
    cyc(0, 1, 14'h1234, 0, 1, 0, 1);
    cyc(1, 1, 14'h0000, good_par(14'h1234), 0, 0, 1);
    idle(4);
    // R5/R7/R8: capture on cs1, bad parity
    cyc(1, 0, 14'h3FFF, 0, 1, 1, 0);
    cyc(1, 1, 14'h0101, ~good_par(14'h3FFF), 1, 1, 0);
    idle(6);
    // R9: two failing commands back to back
    cyc(0, 0, 14'h0001, 0, 0, 0, 1);
    cyc(0, 1, 14'h0003, ~good_par(14'h0001), 0, 1, 1);
    cyc(1, 1, 14'h0000, ~good_par(14'h0003), 1, 0, 1);
    idle(6);
    // R9: failures two cycles apart
    cyc(0, 1, 14'h00F0, 0, 0, 0, 0);
    cyc(1, 1, 14'h0000, ~good_par(14'h00F0), 0, 0, 0);
    cyc(1, 0, 14'h0F00, 0, 0, 0, 0);
    cyc(1, 1, 14'h0000, ~good_par(14'h0F00), 0, 0, 0);
    idle(6);
    // R5: parity on non-check cycles ignored
    cyc(1, 1, 14'h0000, 0, 0, 0, 0);
    cyc(1, 1, 14'h0000, 1, 0, 0, 0);
    idle(3);

    // R10: async reset during an error pulse
    cyc(0, 1, 14'h2222, 0, 1, 1, 1);
    cyc(1, 1, 14'h0000, ~good_par(14'h2222), 1, 1, 1);
    cyc(1, 1, 14'h0000, 0, 1, 1, 1);
    cyc(1, 1, 14'h0000, 0, 1, 1, 1);
    #3 rst_n = 1'b0;
    #2 compare_all();
    @(negedge clk);
    compare_all();
    #5 rst_n = 1'b1;
    @(negedge clk);
    compare_all();
    idle(4);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      bit c0, c1, bad;
      logic [LANES-1:0] d;
      c0  = ($urandom % 3) != 0;
      c1  = ($urandom % 3) != 0;
      bad = ($urandom % 6) == 0;
      d   = LANES'($urandom);
      cyc(c0, c1, d, good_par(m_data) ^ bad, 1'($urandom), 1'($urandom),
          (($urandom % 50) == 0) ? ~m_role : m_role);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule